// File: doc/BRIEF.md
# Full-Speed USB Line-State Interface

This block holds the digital control and line-state logic of a full-speed USB physical-layer front end. On the transmit side it turns an active-low output enable, a force-SE0 request and a data bit into a driver enable and a pair of D+/D- levels. On the receive side it takes D+ and D- levels that have already been sampled and brings them out as two single-ended outputs. It also produces a differential receive output that keeps its value through single-ended-zero periods.

A two-bit mode input selects the operating state. Disconnect and full-speed behave the same, except that full-speed turns on the D+ pull-up. The other two codes park the driver. A suspend input turns off the differential receiver and leaves the single-ended path working, so that resume signalling can still be seen. The analog drivers, thresholds, termination, clocking, bit stuffing and NRZI coding are handled elsewhere.

Top module: `usb_fs_line_if`

## Requirements
- R1: The driver is enabled (drive_en_o=1) only when oe_ni=0 and mode_i is 2'b00 (disconnect) or 2'b01 (full-speed). In every other case drive_en_o, drive_dp_o and drive_dm_o are all 0.
- R2: While the driver is enabled and se0_force_i=1, drive_dp_o=0 and drive_dm_o=0, whatever tx_data_i is.
- R3: While the driver is enabled and se0_force_i=0, tx_data_i=1 drives J (drive_dp_o=1, drive_dm_o=0) and tx_data_i=0 drives K (drive_dp_o=0, drive_dm_o=1).
- R4: se_dp_o equals line_dp_i and se_dm_o equals line_dm_i in the same cycle, whatever the values of oe_ni, mode_i and suspend_i.
- R5: With suspend_i=0, a J on the lines (dp=1, dm=0) gives rcv_o=1 and a K (dp=0, dm=1) gives rcv_o=0, in the same cycle.
- R6: With suspend_i=0, an SE0 (dp=0, dm=0) or SE1 (dp=1, dm=1) on the lines gives rcv_o equal to the last J/K value captured at a rising clock edge.
- R7: While suspend_i=1, rcv_o=0 and no J/K value is captured, so after suspend ends an SE0 shows the value held from before the suspend.
- R8: pullup_en_o is 1 one clock after a rising edge that sees mode_i=2'b01, and 0 one clock after any other mode.
- R9: Asserting rst_ni low at once clears the held receive value to 0 and sets pullup_en_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode: 00 disconnect, 01 full-speed, 10/11 parked |
| suspend_i | input | 1 | Suspend: differential receiver off |
| oe_ni | input | 1 | Transmit output enable, active low |
| se0_force_i | input | 1 | Force SE0 on the lines while transmitting |
| tx_data_i | input | 1 | Transmit data: 1 gives J, 0 gives K |
| line_dp_i | input | 1 | Sampled D+ level |
| line_dm_i | input | 1 | Sampled D- level |
| drive_en_o | output | 1 | Line driver enable |
| drive_dp_o | output | 1 | Level driven on D+ |
| drive_dm_o | output | 1 | Level driven on D- |
| pullup_en_o | output | 1 | D+ pull-up enable |
| se_dp_o | output | 1 | Single-ended D+ receiver output |
| se_dm_o | output | 1 | Single-ended D- receiver output |
| rcv_o | output | 1 | Differential receive output |

## Verification
The only state is the held receive bit and the pull-up flag. A corrupted held bit stays hidden while the lines carry J or K. It shows up on rcv_o in the first cycle of SE0 or SE1 after suspend is released. For that reason the bench places SE0 directly after J, after K, and after a suspend that saw K. A wrong pull-up flag shows on pullup_en_o one clock after the mode changes, and a reset that fails to clear it shows during the reset itself.

// File: rtl/usb_fs_line_pkg.sv
package usb_fs_line_pkg;

  typedef enum logic [1:0] {
    MODE_DISC = 2'b00,
    MODE_FS   = 2'b01,
    MODE_PK2  = 2'b10,
    MODE_PK3  = 2'b11
  } line_mode_e;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_state_e;

  function automatic line_state_e decode_line(input logic dp, input logic dm);
    return line_state_e'({dp, dm});
  endfunction

endpackage

// File: rtl/usb_fs_mode_ctl.sv
module usb_fs_mode_ctl
  import usb_fs_line_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output logic       mode_act_o,
  output logic       pullup_en_o
);

  line_mode_e mode;
  logic       pullup_q;

  assign mode       = line_mode_e'(mode_i);
  assign mode_act_o = (mode == MODE_DISC) || (mode == MODE_FS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pullup_q <= 1'b0;
    else         pullup_q <= (mode == MODE_FS);
  end

  assign pullup_en_o = pullup_q;

  a_r8_pullup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (pullup_en_o == ($past(mode_i) == 2'b01)));

endmodule

// File: rtl/usb_fs_tx_drv.sv
module usb_fs_tx_drv (
  input  logic mode_act_i,
  input  logic oe_ni,
  input  logic se0_force_i,
  input  logic tx_data_i,
  output logic drive_en_o,
  output logic drive_dp_o,
  output logic drive_dm_o
);

  always_comb begin
    drive_en_o = mode_act_i && !oe_ni;
    drive_dp_o = 1'b0;
    drive_dm_o = 1'b0;
    if (drive_en_o && !se0_force_i) begin
      drive_dp_o = tx_data_i;
      drive_dm_o = !tx_data_i;
    end
  end

endmodule

// File: rtl/usb_fs_rx_line.sv
module usb_fs_rx_line
  import usb_fs_line_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic suspend_i,
  input  logic line_dp_i,
  input  logic line_dm_i,
  output logic se_dp_o,
  output logic se_dm_o,
  output logic rcv_o
);

  line_state_e ls;
  logic        held_q;
  logic        diff_val;

  assign ls      = decode_line(line_dp_i, line_dm_i);
  assign se_dp_o = line_dp_i;
  assign se_dm_o = line_dm_i;

  // J/K passes straight through; SE0/SE1 falls back to the held value
  always_comb begin
    unique case (ls)
      LS_J:    diff_val = 1'b1;
      LS_K:    diff_val = 1'b0;
      default: diff_val = held_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else if (!suspend_i && (ls == LS_J || ls == LS_K)) held_q <= (ls == LS_J);
  end

  assign rcv_o = suspend_i ? 1'b0 : diff_val;

  a_r7_suspend_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |-> !rcv_o);

  a_r6_hold_se0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !suspend_i && !$past(suspend_i) && (line_dp_i == line_dm_i))
      |-> (rcv_o == $past(rcv_o)));

  a_r5_jk_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!suspend_i && (line_dp_i != line_dm_i)) |-> (rcv_o == line_dp_i));

endmodule

// File: rtl/usb_fs_line_if.sv
module usb_fs_line_if (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       suspend_i,
  input  logic       oe_ni,
  input  logic       se0_force_i,
  input  logic       tx_data_i,
  input  logic       line_dp_i,
  input  logic       line_dm_i,
  output logic       drive_en_o,
  output logic       drive_dp_o,
  output logic       drive_dm_o,
  output logic       pullup_en_o,
  output logic       se_dp_o,
  output logic       se_dm_o,
  output logic       rcv_o
);

  logic mode_act;

  usb_fs_mode_ctl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .mode_act_o  (mode_act),
    .pullup_en_o (pullup_en_o)
  );

  usb_fs_tx_drv u_tx (
    .mode_act_i  (mode_act),
    .oe_ni       (oe_ni),
    .se0_force_i (se0_force_i),
    .tx_data_i   (tx_data_i),
    .drive_en_o  (drive_en_o),
    .drive_dp_o  (drive_dp_o),
    .drive_dm_o  (drive_dm_o)
  );

  usb_fs_rx_line u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .suspend_i (suspend_i),
    .line_dp_i (line_dp_i),
    .line_dm_i (line_dm_i),
    .se_dp_o   (se_dp_o),
    .se_dm_o   (se_dm_o),
    .rcv_o     (rcv_o)
  );

  a_r1_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || mode_i[1]) |-> (!drive_en_o && !drive_dp_o && !drive_dm_o));

  a_r2_force_se0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o && se0_force_i) |-> (!drive_dp_o && !drive_dm_o));

  a_r3_jk_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o && !se0_force_i) |-> (drive_dp_o == tx_data_i && drive_dm_o == !tx_data_i));

endmodule

// File: tb/usb_fs_line_if_bench.sv
module usb_fs_line_if_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic susp = 1'b0, oe_n = 1'b1, se0f = 1'b0, txd = 1'b0, dp = 1'b0, dm = 1'b0;
  logic den, ddp, ddm, pu, sdp, sdm, rcv;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  usb_fs_line_if u_usb_fs_line_if (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .suspend_i(susp),
    .oe_ni(oe_n), .se0_force_i(se0f), .tx_data_i(txd),
    .line_dp_i(dp), .line_dm_i(dm),
    .drive_en_o(den), .drive_dp_o(ddp), .drive_dm_o(ddm),
    .pullup_en_o(pu), .se_dp_o(sdp), .se_dm_o(sdm), .rcv_o(rcv)
  );

  // {mode[1:0], oe_n, se0f, txd, dp, dm, exp den, ddp, ddm, sdp, sdm}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    12'b00_0_0_1_10_11010,  // R1 R3 disconnect J
    12'b01_0_0_0_01_10101,  // R3 full-speed K
    12'b01_0_1_1_10_10010,  // R2 SE0 over data 1
    12'b00_0_1_0_00_10000,  // R2 SE0 over data 0
    12'b01_1_0_1_10_00010,  // R1 oe high releases
    12'b00_1_1_0_01_00001,  // R1 released, force ignored
    12'b10_0_0_1_10_00010,  // R1 parked mode 10
    12'b11_0_0_0_01_00001,  // R1 parked mode 11
    12'b01_0_0_1_11_11011,  // R4 SE1 on lines while driving
    12'b01_1_0_0_00_00000,  // R4 SE0 on lines
    12'b10_1_1_1_11_00011,  // R4 parked
    12'b00_0_0_0_10_10110   // R3 K driven, lines J
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic put_line(input logic p, input logic m, input logic s);
    @(negedge clk);
    dp = p; dm = m; susp = s;
    #2;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state
    mode = 2'b01;
    repeat (3) @(negedge clk);
    chk("R9 pullup in reset", {7'b0, pu}, 8'd0);
    dp = 1'b0; dm = 1'b0;
    #1;
    chk("R9 held value after reset", {7'b0, rcv}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // vector table, combinational outputs
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {mode, oe_n, se0f, txd, dp, dm} = VEC[i][11:5];
      #2;
      chk($sformatf("R1-3/R4 vec%0d", i), {3'b0, den, ddp, ddm, sdp, sdm}, {3'b0, VEC[i][4:0]});
    end

    // R8 pull-up follows mode one clock later
    @(negedge clk); mode = 2'b01; oe_n = 1'b1;
    @(negedge clk); chk("R8 fs pullup", {7'b0, pu}, 8'd1);
    mode = 2'b00;
    @(negedge clk); chk("R8 disconnect pullup", {7'b0, pu}, 8'd0);
    mode = 2'b10;
    @(negedge clk); chk("R8 parked pullup", {7'b0, pu}, 8'd0);
    mode = 2'b01;
    @(negedge clk); chk("R8 fs again", {7'b0, pu}, 8'd1);
    #1 rst_n = 1'b0; #1;
    chk("R9 async pullup clear", {7'b0, pu}, 8'd0);
    @(negedge clk); rst_n = 1'b1;

    // R5 R6 receive and hold
    put_line(1, 0, 0); chk("R5 J rcv", {7'b0, rcv}, 8'd1);
    put_line(0, 0, 0); chk("R6 SE0 holds J", {7'b0, rcv}, 8'd1);
    put_line(1, 1, 0); chk("R6 SE1 holds J", {7'b0, rcv}, 8'd1);
    put_line(0, 1, 0); chk("R5 K rcv", {7'b0, rcv}, 8'd0);
    put_line(0, 0, 0); chk("R6 SE0 holds K", {7'b0, rcv}, 8'd0);
    put_line(1, 0, 0); chk("R5 J again", {7'b0, rcv}, 8'd1);

    // R7 suspend
    put_line(1, 0, 1); chk("R7 suspend J rcv low", {7'b0, rcv}, 8'd0);
    chk("R4 se during suspend J", {6'b0, sdp, sdm}, 8'b10);
    put_line(0, 1, 1); chk("R7 suspend K rcv low", {7'b0, rcv}, 8'd0);
    chk("R4 resume K visible", {6'b0, sdp, sdm}, 8'b01);
    put_line(0, 1, 1);
    put_line(0, 0, 0); chk("R7 held kept over suspend", {7'b0, rcv}, 8'd1);

    // R9 reset clears held value
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #2;
    chk("R9 SE0 after reset", {7'b0, rcv}, 8'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule